// File: doc/BRIEF.md
# DMA Burst Cycle Timing Engine

This block charges a cycle cost to every unit that a DMA channel moves. A unit is one read from the source followed by one write to the destination. Either side may sit in a slow main memory that supports bursts, or in some other region. For each main-memory access the engine decides whether it opens a new burst, which is charged at the nonsequential rate, or continues one, which is charged at the sequential rate. Each burst has a length limit that depends on direction and width, and reads in 16-bit mode follow an uneven repeating limit.

A unit is presented for one cycle on `unit_vld_i`, together with its width, its region flags, its address step mode, its address offset inside a 32-byte block and the current cost figures. One cycle later the engine returns the unit's cost, a flag saying that the main-memory access was nonsequential, and the updated running total for the transfer. A pulse on `xfer_start_i` begins a new transfer. It clears the burst history and the running total.

Top module: `dma_burst_timer`

## Requirements
- R1: After reset, `cost_vld_o`, `cost_o`, `burst_first_o` and `total_o` are all zero.
- R2: The unit cost is the read charge plus the write charge. An access outside main memory is charged `oth_cost_i`. A unit that touches no main memory costs twice `oth_cost_i` and reports `burst_first_o` = 0.
- R3: A write to main memory with an incrementing address (step_i = 2'b00) while the source is elsewhere is charged `main_nseq_i` on the first unit of a burst and `main_seq_i` on every other unit. A burst holds at most 120 units when wide_i = 0 (16-bit) and at most 80 units when wide_i = 1 (32-bit).
- R4: A read from main memory with an incrementing address while the destination is elsewhere is charged `main_nseq_i` − 1 on the first unit of a burst, because the read overlaps the write elsewhere, and `main_seq_i` on every other unit. In 32-bit mode a burst holds at most 118 units.
- R5: In 16-bit mode, incrementing reads from main memory form bursts whose lengths repeat as 119, 119, 2.
- R6: When both source and destination are main memory, every unit costs 2 × `main_nseq_i` and reports `burst_first_o` = 1, whatever the step mode.
- R7: With step_i = 2'b01 (decrement), 2'b10 or 2'b11 (fixed), every main-memory access is nonsequential. A read from main memory with the destination elsewhere is charged `main_nseq_i` − 1. It is charged one cycle less again when the access holds the last halfword of a 32-byte block: `hw_ofs_i` (address bits 4:1) = 4'b1111 in 16-bit mode, or `hw_ofs_i`[3:1] = 3'b111 in 32-bit mode. Writes get no such discount.
- R8: `xfer_start_i` clears the burst history and the running total. A unit presented in the same cycle is the first unit of a fresh burst.
- R9: `total_o` is the sum of the costs of all units since the last `xfer_start_i`, including a unit presented with the start pulse.
- R10: `cost_vld_o`, `cost_o` and `burst_first_o` respond in the cycle after `unit_vld_i`. `cost_vld_o` is high only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_start_i | input | 1 | Begins a new transfer |
| unit_vld_i | input | 1 | A unit is presented this cycle |
| wide_i | input | 1 | 1 = 32-bit units, 0 = 16-bit units |
| src_main_i | input | 1 | Source lies in main memory |
| dst_main_i | input | 1 | Destination lies in main memory |
| step_i | input | 2 | 00 increment, 01 decrement, 10/11 fixed |
| hw_ofs_i | input | OFS_W (4) | Address bits 4:1 of the main-memory access |
| main_nseq_i | input | CW (5) | Main-memory nonsequential cost |
| main_seq_i | input | CW (5) | Main-memory sequential cost |
| oth_cost_i | input | CW (5) | Cost of an access outside main memory |
| cost_vld_o | output | 1 | Cost outputs belong to the unit of the previous cycle |
| cost_o | output | CW+1 (6) | Cycle cost of that unit |
| burst_first_o | output | 1 | The unit's main-memory access was nonsequential |
| total_o | output | TOT_W (24) | Running cycle total of the transfer |

## Verification
The bench builds the engine with its default burst limits of 120, 80, 118 and 119/2, with the uneven 16-bit read pattern enabled, and with 5-bit costs. Nominal costs are 8 cycles nonsequential, 2 cycles sequential and 3 cycles elsewhere. With these values a run of about 240 halfword reads reaches both long bursts and the two-unit tail, and resumes the pattern afterwards. Each of the three other limits is crossed by a run a few units longer than that limit. The 5-bit cost width leaves room for a same-region unit of 16 cycles without overflow.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

   typedef enum logic [1:0] {
      STEP_INC = 2'b00,
      STEP_DEC = 2'b01,
      STEP_FIX = 2'b10,
      STEP_RSV = 2'b11
   } step_e;

   function automatic int cap_max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/dbt_burst_track.sv
module dbt_burst_track #(
   parameter int WR16_CAP   = 120,
   parameter int WR32_CAP   = 80,
   parameter int RD32_CAP   = 118,
   parameter int RD16_CAP   = 119,
   parameter int RD16_TAIL  = 2,
   parameter bit RD16_SPLIT = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic restart_i,
   input  logic adv_i,
   input  logic brk_i,
   input  logic wide_i,
   input  logic rd_i,
   output logic first_o
);
   localparam int MAXCAP = dbt_pkg::cap_max4(WR16_CAP, WR32_CAP, RD32_CAP, RD16_CAP);
   localparam int CNT_W  = $clog2(MAXCAP + 1);

   logic [CNT_W-1:0] cnt_q, eff_cnt, cnt_nxt, cap, rd16_cap;
   logic [1:0]       ph_q, eff_ph, ph_nxt;
   logic             burst_end;

   assign eff_cnt = restart_i ? '0 : cnt_q;
   assign eff_ph  = restart_i ? 2'd0 : ph_q;

   generate
      if (RD16_SPLIT) begin : g_split
         assign rd16_cap = (eff_ph == 2'd2) ? CNT_W'(RD16_TAIL) : CNT_W'(RD16_CAP);
      end else begin : g_flat
         assign rd16_cap = CNT_W'(RD16_CAP);
      end
   endgenerate

   always_comb begin
      if (rd_i) cap = wide_i ? CNT_W'(RD32_CAP) : rd16_cap;
      else      cap = wide_i ? CNT_W'(WR32_CAP) : CNT_W'(WR16_CAP);
   end

   assign cnt_nxt   = eff_cnt + 1'b1;
   assign burst_end = (cnt_nxt == cap);
   assign ph_nxt    = (eff_ph == 2'd2) ? 2'd0 : eff_ph + 2'd1;
   assign first_o   = (eff_cnt == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         ph_q  <= 2'd0;
      end else if (adv_i) begin
         cnt_q <= burst_end ? '0 : cnt_nxt;
         ph_q  <= (burst_end && rd_i && !wide_i) ? ph_nxt : eff_ph;
      end else if (brk_i || restart_i) begin
         cnt_q <= '0;
         ph_q  <= 2'd0;
      end
   end

endmodule

// File: rtl/dbt_cost_calc.sv
module dbt_cost_calc #(
   parameter int CW    = 5,
   parameter int OFS_W = 4
) (
   input  logic             wide_i,
   input  logic             src_main_i,
   input  logic             dst_main_i,
   input  logic [1:0]       step_i,
   input  logic [OFS_W-1:0] hw_ofs_i,
   input  logic             burst_head_i,
   input  logic [CW-1:0]    main_nseq_i,
   input  logic [CW-1:0]    main_seq_i,
   input  logic [CW-1:0]    oth_cost_i,
   output logic             seq_ok_o,
   output logic             nonseq_o,
   output logic [CW:0]      cost_o
);
   import dbt_pkg::*;

   logic          inc, same_rgn, main_ns, blk_end, disc;
   logic [CW:0]   mn, ms, oc, rd_c, wr_c;

   assign inc      = (step_e'(step_i) == STEP_INC);
   assign same_rgn = src_main_i && dst_main_i;
   assign seq_ok_o = inc && (src_main_i ^ dst_main_i);
   assign main_ns  = same_rgn || !inc || burst_head_i;
   assign blk_end  = wide_i ? (&hw_ofs_i[OFS_W-1:1]) : (&hw_ofs_i);
   assign disc     = !inc && blk_end;

   assign mn = {1'b0, main_nseq_i};
   assign ms = {1'b0, main_seq_i};
   assign oc = {1'b0, oth_cost_i};

   always_comb begin
      if (!src_main_i)    rd_c = oc;
      else if (same_rgn)  rd_c = mn;
      else if (main_ns)   rd_c = mn - (CW+1)'(1) - (disc ? (CW+1)'(1) : (CW+1)'(0));
      else                rd_c = ms;

      if (!dst_main_i)    wr_c = oc;
      else if (main_ns)   wr_c = mn;
      else                wr_c = ms;
   end

   assign cost_o   = rd_c + wr_c;
   assign nonseq_o = (src_main_i || dst_main_i) && main_ns;

endmodule

// File: rtl/dma_burst_timer.sv
module dma_burst_timer #(
   parameter int CW        = 5,
   parameter int TOT_W     = 24,
   parameter int BLK_BYTES = 32,
   parameter int WR16_CAP  = 120,
   parameter int WR32_CAP  = 80,
   parameter int RD32_CAP  = 118,
   parameter int RD16_CAP  = 119,
   parameter int RD16_TAIL = 2,
   parameter bit RD16_SPLIT = 1'b1,
   localparam int OFS_W    = $clog2(BLK_BYTES) - 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             xfer_start_i,
   input  logic             unit_vld_i,
   input  logic             wide_i,
   input  logic             src_main_i,
   input  logic             dst_main_i,
   input  logic [1:0]       step_i,
   input  logic [OFS_W-1:0] hw_ofs_i,
   input  logic [CW-1:0]    main_nseq_i,
   input  logic [CW-1:0]    main_seq_i,
   input  logic [CW-1:0]    oth_cost_i,
   output logic             cost_vld_o,
   output logic [CW:0]      cost_o,
   output logic             burst_first_o,
   output logic [TOT_W-1:0] total_o
);

   initial begin
      assert (CW >= 2) else $error("dma_burst_timer: CW too small");
      assert (TOT_W > CW) else $error("dma_burst_timer: TOT_W must exceed CW");
      assert (BLK_BYTES >= 8 && (BLK_BYTES & (BLK_BYTES - 1)) == 0)
         else $error("dma_burst_timer: BLK_BYTES must be a power of two >= 8");
      assert (WR16_CAP > 1 && WR32_CAP > 1 && RD32_CAP > 1 && RD16_CAP > 1 && RD16_TAIL > 0)
         else $error("dma_burst_timer: burst caps out of range");
   end

   logic             head, seq_ok, nonseq;
   logic [CW:0]      unit_cost;
   logic             vld_q, first_q;
   logic [CW:0]      cost_q;
   logic [TOT_W-1:0] tot_q;

   dbt_burst_track #(
      .WR16_CAP  (WR16_CAP),
      .WR32_CAP  (WR32_CAP),
      .RD32_CAP  (RD32_CAP),
      .RD16_CAP  (RD16_CAP),
      .RD16_TAIL (RD16_TAIL),
      .RD16_SPLIT(RD16_SPLIT)
   ) trk_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .restart_i(xfer_start_i),
      .adv_i    (unit_vld_i && seq_ok),
      .brk_i    (unit_vld_i && !seq_ok),
      .wide_i   (wide_i),
      .rd_i     (src_main_i),
      .first_o  (head)
   );

   dbt_cost_calc #(
      .CW   (CW),
      .OFS_W(OFS_W)
   ) calc_i (
      .wide_i      (wide_i),
      .src_main_i  (src_main_i),
      .dst_main_i  (dst_main_i),
      .step_i      (step_i),
      .hw_ofs_i    (hw_ofs_i),
      .burst_head_i(head),
      .main_nseq_i (main_nseq_i),
      .main_seq_i  (main_seq_i),
      .oth_cost_i  (oth_cost_i),
      .seq_ok_o    (seq_ok),
      .nonseq_o    (nonseq),
      .cost_o      (unit_cost)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vld_q   <= 1'b0;
         first_q <= 1'b0;
         cost_q  <= '0;
         tot_q   <= '0;
      end else begin
         vld_q <= unit_vld_i;
         if (unit_vld_i) begin
            first_q <= nonseq;
            cost_q  <= unit_cost;
            tot_q   <= (xfer_start_i ? '0 : tot_q) + TOT_W'(unit_cost);
         end else if (xfer_start_i) begin
            tot_q <= '0;
         end
      end
   end

   assign cost_vld_o    = vld_q;
   assign cost_o        = cost_q;
   assign burst_first_o = first_q;
   assign total_o       = tot_q;

endmodule

// File: rtl/dma_burst_timer_chk.sv
module dma_burst_timer_chk #(
   parameter int CW    = 5,
   parameter int TOT_W = 24
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             xfer_start_i,
   input logic             unit_vld_i,
   input logic             src_main_i,
   input logic             dst_main_i,
   input logic [1:0]       step_i,
   input logic             cost_vld_o,
   input logic [CW:0]      cost_o,
   input logic             burst_first_o,
   input logic [TOT_W-1:0] total_o
);

   p_accum_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unit_vld_i && !xfer_start_i |=> total_o == TOT_W'($past(total_o) + TOT_W'(cost_o)));

   p_start_unit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unit_vld_i && xfer_start_i |=> total_o == TOT_W'(cost_o));

   p_start_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      xfer_start_i && !unit_vld_i |=> total_o == '0);

   p_same_rgn_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unit_vld_i && src_main_i && dst_main_i |=> burst_first_o);

   p_nonlinear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unit_vld_i && (step_i != 2'b00) && (src_main_i || dst_main_i) |=> burst_first_o);

   p_no_main_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unit_vld_i && !src_main_i && !dst_main_i |=> !burst_first_o);

   p_vld_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unit_vld_i |=> cost_vld_o);

   p_vld_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !unit_vld_i |=> !cost_vld_o && $stable(cost_o));

endmodule

bind dma_burst_timer dma_burst_timer_chk #(.CW(CW), .TOT_W(TOT_W)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .xfer_start_i (xfer_start_i),
   .unit_vld_i   (unit_vld_i),
   .src_main_i   (src_main_i),
   .dst_main_i   (dst_main_i),
   .step_i       (step_i),
   .cost_vld_o   (cost_vld_o),
   .cost_o       (cost_o),
   .burst_first_o(burst_first_o),
   .total_o      (total_o)
);

// File: tb/dma_burst_timer_tb_top.sv
`timescale 1ns/100ps
module dma_burst_timer_tb_top;

   localparam int CW    = 5;
   localparam int TOT_W = 24;
   localparam int MN = 8, MS = 2, OC = 3;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             start, uv, wide, srcm, dstm;
   logic [1:0]       step;
   logic [3:0]       ofs;
   logic [CW-1:0]    mn_c, ms_c, oc_c;
   logic             cvld, cfirst;
   logic [CW:0]      cost;
   logic [TOT_W-1:0] total;

   int total_chk = 0;
   int bad_chk   = 0;
   bit done      = 1'b0;

   always #2.5 clk = ~clk;

   dma_burst_timer #(.CW(CW), .TOT_W(TOT_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .xfer_start_i(start), .unit_vld_i(uv),
      .wide_i(wide), .src_main_i(srcm), .dst_main_i(dstm), .step_i(step),
      .hw_ofs_i(ofs), .main_nseq_i(mn_c), .main_seq_i(ms_c), .oth_cost_i(oc_c),
      .cost_vld_o(cvld), .cost_o(cost), .burst_first_o(cfirst), .total_o(total)
   );

   // vector fields: wide, src, dst, step[1:0], ofs[3:0], exp_cost[5:0], exp_first
   localparam int NV = 11;
   localparam logic [15:0] VEC [NV] = '{
      {1'b0, 1'b1, 1'b0, 2'b00, 4'h0, 6'd10, 1'b1},  // R4 read head, overlap
      {1'b1, 1'b0, 1'b1, 2'b00, 4'h0, 6'd11, 1'b1},  // R3 write head
      {1'b0, 1'b1, 1'b1, 2'b00, 4'h0, 6'd16, 1'b1},  // R6 same region
      {1'b0, 1'b0, 1'b0, 2'b00, 4'h0, 6'd6,  1'b0},  // R2 no main memory
      {1'b0, 1'b1, 1'b0, 2'b10, 4'hF, 6'd9,  1'b1},  // R7 fixed, block end 16
      {1'b0, 1'b1, 1'b0, 2'b10, 4'hE, 6'd10, 1'b1},  // R7 fixed, not block end
      {1'b1, 1'b1, 1'b0, 2'b01, 4'hE, 6'd9,  1'b1},  // R7 dec, block end 32
      {1'b1, 1'b1, 1'b0, 2'b01, 4'hC, 6'd10, 1'b1},  // R7 dec, not block end
      {1'b0, 1'b0, 1'b1, 2'b01, 4'hF, 6'd11, 1'b1},  // R7 write, no discount
      {1'b1, 1'b1, 1'b1, 2'b11, 4'hF, 6'd16, 1'b1},  // R6 same region fixed
      {1'b0, 1'b0, 1'b0, 2'b10, 4'hF, 6'd6,  1'b0}   // R2 no main, fixed
   };

   task automatic chk(input string tag, input int act, input int exp);
      total_chk++;
      if (act !== exp) begin
         bad_chk++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step_unit(input logic w, input logic s, input logic d,
                            input logic [1:0] st, input logic [3:0] o, input logic stt);
      start = stt; uv = 1'b1; wide = w; srcm = s; dstm = d; step = st; ofs = o;
      @(posedge clk); #1;
      start = 1'b0; uv = 1'b0;
   endtask

   // runs n incrementing units and models bursts independently
   task automatic run_burst(input logic w, input logic s, input logic d,
                            input int n, input string tag);
      int bc, ph, cap, ec, sum;
      logic [31:0] a;
      bc = 0; ph = 0; sum = 0; a = 32'h0200_0000;
      for (int i = 0; i < n; i++) begin
         step_unit(w, s, d, 2'b00, a[4:1], i == 0);
         if (s) ec = (bc == 0) ? (MN - 1 + OC) : (MS + OC);
         else   ec = (bc == 0) ? (OC + MN) : (OC + MS);
         chk({tag, " cost"}, int'(cost), ec);
         chk({tag, " first"}, int'(cfirst), int'(bc == 0));
         sum += ec;
         if (s) cap = w ? 118 : ((ph == 2) ? 2 : 119);
         else   cap = w ? 80 : 120;
         bc++;
         if (bc == cap) begin
            bc = 0;
            if (s && !w) ph = (ph + 1) % 3;
         end
         a = a + (w ? 32'd4 : 32'd2);
      end
      chk({tag, " total (R9)"}, int'(total), sum);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total_chk++;
         bad_chk++;
         $display("FAIL watchdog (R10): actual=hung expected=completion");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; uv = 1'b0; wide = 1'b0; srcm = 1'b0; dstm = 1'b0;
      step = 2'b00; ofs = 4'h0;
      mn_c = CW'(MN); ms_c = CW'(MS); oc_c = CW'(OC);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      chk("R1 cost_vld", int'(cvld), 0);
      chk("R1 cost", int'(cost), 0);
      chk("R1 first", int'(cfirst), 0);
      chk("R1 total", int'(total), 0);

      // table of single-unit vectors, each a fresh transfer (R2 R6 R7 R8)
      for (int v = 0; v < NV; v++) begin
         step_unit(VEC[v][15], VEC[v][14], VEC[v][13], VEC[v][12:11], VEC[v][10:7], 1'b1);
         chk($sformatf("vector %0d cost (R2 R3 R4 R6 R7)", v), int'(cost), int'(VEC[v][6:1]));
         chk($sformatf("vector %0d first (R2 R6 R7)", v), int'(cfirst), int'(VEC[v][0]));
         chk($sformatf("vector %0d vld (R10)", v), int'(cvld), 1);
         chk($sformatf("vector %0d total (R8)", v), int'(total), int'(VEC[v][6:1]));
      end

      // R10 idle cycle after a unit
      @(posedge clk); #1;
      chk("R10 vld drops", int'(cvld), 0);
      chk("R10 cost holds", int'(cost), 6);

      // burst limits
      run_burst(1'b0, 1'b1, 1'b0, 245, "R5 rd16 119/119/2");
      run_burst(1'b1, 1'b1, 1'b0, 121, "R4 rd32 118");
      run_burst(1'b0, 1'b0, 1'b1, 123, "R3 wr16 120");
      run_burst(1'b1, 1'b0, 1'b1, 83,  "R3 wr32 80");

      // R8 restart mid-burst
      for (int i = 0; i < 5; i++) step_unit(1'b0, 1'b0, 1'b1, 2'b00, 4'(i), i == 0);
      chk("R8 mid-burst sequential cost", int'(cost), OC + MS);
      step_unit(1'b0, 1'b0, 1'b1, 2'b00, 4'h5, 1'b1);
      chk("R8 restart first", int'(cfirst), 1);
      chk("R8 restart cost", int'(cost), OC + MN);
      chk("R8 restart total", int'(total), OC + MN);
      start = 1'b1; @(posedge clk); #1; start = 1'b0;
      chk("R8 start alone clears total", int'(total), 0);
      chk("R10 no unit no vld", int'(cvld), 0);

      // R7 fixed-address writes never form a burst
      for (int i = 0; i < 3; i++) begin
         step_unit(1'b0, 1'b0, 1'b1, 2'b10, 4'h0, i == 0);
         chk("R7 fixed write stays nonsequential", int'(cost), OC + MN);
      end
      chk("R9 total after fixed writes", int'(total), 3 * (OC + MN));

      finish_run();
   end

endmodule